// File: doc/BRIEF.md
# Periodic Microframe Transaction Scheduler

This block picks the interrupt transactions a high-speed USB 2.0 host starts in each 125 µs microframe. It holds a small table of interrupt endpoint descriptors. Each descriptor has an enable, an 8-bit start mask, a poll-interval exponent and a maximum packet size. On every start-of-microframe strobe it advances its frame index and reloads a byte-time budget. It then walks the table from the lowest index upwards. For each eligible entry it hands one transaction to a downstream transaction engine, and it waits for that engine's done pulse before it looks at the next entry.

The block never starts a transaction that cannot finish before the end-of-microframe guard point. The cost of an entry is its packet size plus a fixed per-transaction overhead. Once one eligible entry is refused for lack of time, every eligible entry after it in that microframe is dropped as well. Dropped work is never carried into a later microframe. A per-microframe drop count and a sticky overflow flag show software when it should spread the start-mask bits over more microframes.

Top module: `periodic_uframe_sched`

## Requirements
- R1: After reset `frindex` is all ones, `txn_start` is low, `drop_count` is 0 and `overflow` is 0. Each `uframe_start` pulse adds one to `frindex`, so the first microframe after reset has index 0.
- R2: An entry is eligible only when its enable bit is 1 and bit `frindex[2:0]` of its 8-bit start mask is 1. An entry with an all-zero mask is never eligible.
- R3: The interval field `k` (3 bits) makes an entry eligible only in frames where the frame number (`frindex >> 3`) has its low `k` bits equal to zero. That is every 2^k frames, and `k = 0` means every frame.
- R4: Within a microframe, grants go out in strictly ascending table index. At most one transaction is outstanding at a time. The next entry is evaluated only after `txn_done`.
- R5: A grant is a one-cycle `txn_start` pulse. At the same time `txn_idx` carries the entry's index and `txn_bytes` carries its packet size.
- R6: At each `uframe_start` the budget is loaded with `UFRAME_BYTES - EOF1_GUARD`. An entry costs its packet size plus `TXN_OVERHEAD`. It is granted when that cost is at most the remaining budget, and a grant subtracts the cost. An exact fit is granted, and one byte more is refused.
- R7: After the first refusal in a microframe, every later eligible entry in that microframe is dropped, even one whose cost would still fit.
- R8: `drop_count` counts the eligible entries dropped in the current microframe. It is zero right after each `uframe_start`. A dropped entry is not retried in later microframes beyond its own schedule.
- R9: `overflow` becomes 1 on the first drop and stays 1 until reset.
- R10: A write with `cfg_we` stores enable, mask, interval and size into entry `cfg_idx`. The stored values govern every later microframe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| uframe_start | input | 1 | Start-of-microframe strobe |
| txn_done | input | 1 | Transaction engine finished the outstanding transaction |
| cfg_we | input | 1 | Table write enable |
| cfg_idx | input | $clog2(N_ENTRIES) | Table entry to write |
| cfg_en | input | 1 | Entry enable |
| cfg_smask | input | 8 | Start mask, one bit per microframe of a frame |
| cfg_ivl | input | 3 | Poll interval exponent (period 2^k frames) |
| cfg_pkt | input | PKT_W | Maximum packet size in bytes |
| txn_start | output | 1 | One-cycle grant pulse |
| txn_idx | output | $clog2(N_ENTRIES) | Index of the granted entry |
| txn_bytes | output | PKT_W | Packet size of the granted entry |
| frindex | output | FRAME_W+3 | Microframe index |
| drop_count | output | $clog2(N_ENTRIES+1) | Entries dropped in the current microframe |
| overflow | output | 1 | Sticky drop indicator |

## Verification
The bench builds the block with eight entries, `UFRAME_BYTES = 3000`, `EOF1_GUARD = 200` and `TXN_OVERHEAD = 40`, which gives a budget of 2800 byte-times. With this budget, two 1024-byte entries fit and a third does not. Five 512-byte entries would all fit. That puts the fit boundary in reach with a handful of entries, and it makes exact-fit and one-byte-over cases easy to set up. `FRAME_W = 11` with microframes counted from 0 lets a two-frame interval and the frame-to-frame repetition of the same shortfall show up within about forty microframes.

// File: rtl/uframe_sched_pkg.sv
package uframe_sched_pkg;
  localparam int SMASK_W = 8;
  localparam int IVL_W   = 3;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_EVAL,
    ST_WAIT
  } sched_state_t;
endpackage

// File: rtl/uframe_qh_table.sv
module uframe_qh_table
  import uframe_sched_pkg::*;
#(
  parameter int N_ENTRIES = 8,
  parameter int PKT_W     = 11,
  localparam int AW       = $clog2(N_ENTRIES)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               we,
  input  logic [AW-1:0]      waddr,
  input  logic               wen,
  input  logic [SMASK_W-1:0] wsmask,
  input  logic [IVL_W-1:0]   wivl,
  input  logic [PKT_W-1:0]   wpkt,
  input  logic [AW-1:0]      raddr,
  output logic               ren,
  output logic [SMASK_W-1:0] rsmask,
  output logic [IVL_W-1:0]   rivl,
  output logic [PKT_W-1:0]   rpkt
);
  logic [SMASK_W+IVL_W+PKT_W-1:0] fld_mem [N_ENTRIES];
  logic [N_ENTRIES-1:0]           en_q;

  // Field storage without reset, so it maps onto distributed RAM.
  always_ff @(posedge clk) begin
    if (we) fld_mem[waddr] <= {wsmask, wivl, wpkt};
  end

  // Enables are kept in flops so the table comes up empty.
  always_ff @(posedge clk) begin
    if (rst)     en_q <= '0;
    else if (we) en_q[waddr] <= wen;
  end

  assign ren = en_q[raddr];
  assign {rsmask, rivl, rpkt} = fld_mem[raddr];
endmodule

// File: rtl/uframe_eligibility.sv
module uframe_eligibility
  import uframe_sched_pkg::*;
#(
  parameter int FRAME_W = 11
) (
  input  logic               en,
  input  logic [SMASK_W-1:0] smask,
  input  logic [IVL_W-1:0]   ivl,
  input  logic [FRAME_W+2:0] frindex,
  output logic               elig
);
  logic [FRAME_W-1:0] frame_num;
  logic [FRAME_W-1:0] ivl_mask;
  logic               slot_hit;
  logic               period_hit;

  always_comb begin
    frame_num  = frindex[FRAME_W+2:3];
    ivl_mask   = FRAME_W'((1 << ivl) - 1);
    slot_hit   = smask[frindex[2:0]];
    period_hit = (frame_num & ivl_mask) == '0;
    elig       = en && slot_hit && period_hit;
  end
endmodule

// File: rtl/uframe_budget.sv
module uframe_budget #(
  parameter int PKT_W        = 11,
  parameter int UFRAME_BYTES = 7500,
  parameter int EOF1_GUARD   = 400,
  parameter int TXN_OVERHEAD = 48,
  localparam int BUD_W       = $clog2(UFRAME_BYTES + 1),
  localparam int CW          = ((PKT_W > BUD_W) ? PKT_W : BUD_W) + 1,
  localparam int LOAD_VAL    = UFRAME_BYTES - EOF1_GUARD
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic             grant,
  input  logic [PKT_W-1:0] pkt,
  output logic             fits
);
  logic [BUD_W-1:0] remain_q;
  logic [CW-1:0]    cost;

  always_comb begin
    cost = CW'(pkt) + CW'(TXN_OVERHEAD);
    fits = cost <= CW'(remain_q);
  end

  always_ff @(posedge clk) begin
    if (rst)        remain_q <= '0;
    else if (load)  remain_q <= BUD_W'(LOAD_VAL);
    else if (grant) remain_q <= remain_q - cost[BUD_W-1:0];
  end

  // R6
  grant_fit_chk: assert property (@(posedge clk) disable iff (rst)
    grant |-> fits);

  // R6
  budget_cap_chk: assert property (@(posedge clk) disable iff (rst)
    remain_q <= BUD_W'(LOAD_VAL));
endmodule

// File: rtl/periodic_uframe_sched.sv
module periodic_uframe_sched
  import uframe_sched_pkg::*;
#(
  parameter int N_ENTRIES    = 8,
  parameter int PKT_W        = 11,
  parameter int FRAME_W      = 11,
  parameter int UFRAME_BYTES = 7500,
  parameter int EOF1_GUARD   = 400,
  parameter int TXN_OVERHEAD = 48
) (
  input  logic                             clk,
  input  logic                             rst,
  input  logic                             uframe_start,
  input  logic                             txn_done,
  input  logic                             cfg_we,
  input  logic [$clog2(N_ENTRIES)-1:0]     cfg_idx,
  input  logic                             cfg_en,
  input  logic [7:0]                       cfg_smask,
  input  logic [2:0]                       cfg_ivl,
  input  logic [PKT_W-1:0]                 cfg_pkt,
  output logic                             txn_start,
  output logic [$clog2(N_ENTRIES)-1:0]     txn_idx,
  output logic [PKT_W-1:0]                 txn_bytes,
  output logic [FRAME_W+2:0]               frindex,
  output logic [$clog2(N_ENTRIES+1)-1:0]   drop_count,
  output logic                             overflow
);
  localparam int AW = $clog2(N_ENTRIES);
  localparam int IW = AW + 1;
  localparam int DW = $clog2(N_ENTRIES + 1);

  sched_state_t       state_q;
  logic [IW-1:0]      idx_q;
  logic               refused_q;
  logic               ent_en;
  logic [SMASK_W-1:0] ent_smask;
  logic [IVL_W-1:0]   ent_ivl;
  logic [PKT_W-1:0]   ent_pkt;
  logic               elig, fits, eval_cyc, last_ent, grant, refuse;

  uframe_qh_table #(.N_ENTRIES(N_ENTRIES), .PKT_W(PKT_W)) u_table (
    .clk(clk), .rst(rst), .we(cfg_we), .waddr(cfg_idx), .wen(cfg_en),
    .wsmask(cfg_smask), .wivl(cfg_ivl), .wpkt(cfg_pkt), .raddr(idx_q[AW-1:0]),
    .ren(ent_en), .rsmask(ent_smask), .rivl(ent_ivl), .rpkt(ent_pkt));

  uframe_eligibility #(.FRAME_W(FRAME_W)) u_elig (
    .en(ent_en), .smask(ent_smask), .ivl(ent_ivl), .frindex(frindex), .elig(elig));

  uframe_budget #(.PKT_W(PKT_W), .UFRAME_BYTES(UFRAME_BYTES), .EOF1_GUARD(EOF1_GUARD),
    .TXN_OVERHEAD(TXN_OVERHEAD)) u_budget (
    .clk(clk), .rst(rst), .load(uframe_start), .grant(grant), .pkt(ent_pkt), .fits(fits));

  always_comb begin
    eval_cyc = (state_q == ST_EVAL) && !uframe_start;
    last_ent = idx_q == IW'(N_ENTRIES - 1);
    grant    = eval_cyc && elig && !refused_q && fits;
    refuse   = eval_cyc && elig && !grant;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q    <= ST_IDLE;
      frindex    <= '1;
      idx_q      <= '0;
      refused_q  <= 1'b0;
      drop_count <= '0;
      overflow   <= 1'b0;
      txn_start  <= 1'b0;
      txn_idx    <= '0;
      txn_bytes  <= '0;
    end else begin
      txn_start <= 1'b0;
      if (uframe_start) begin
        frindex    <= frindex + 1'b1;
        idx_q      <= '0;
        refused_q  <= 1'b0;
        drop_count <= '0;
        state_q    <= (state_q == ST_WAIT) ? ST_WAIT : ST_EVAL;
      end else begin
        case (state_q)
          ST_EVAL: begin
            idx_q <= idx_q + 1'b1;
            if (grant) begin
              txn_start <= 1'b1;
              txn_idx   <= idx_q[AW-1:0];
              txn_bytes <= ent_pkt;
              state_q   <= ST_WAIT;
            end else if (last_ent) begin
              state_q <= ST_IDLE;
            end
            if (refuse) begin
              refused_q  <= 1'b1;
              overflow   <= 1'b1;
              drop_count <= drop_count + 1'b1;
            end
          end
          ST_WAIT: begin
            if (txn_done) state_q <= (idx_q == IW'(N_ENTRIES)) ? ST_IDLE : ST_EVAL;
          end
          default: state_q <= ST_IDLE;
        endcase
      end
    end
  end

  // R1
  frindex_step_chk: assert property (@(posedge clk) disable iff (rst)
    uframe_start |=> frindex == $past(frindex) + 1'b1);

  // R4
  single_txn_chk: assert property (@(posedge clk) disable iff (rst)
    txn_start |=> !txn_start);

  // R4
  wait_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_WAIT && !txn_done) |=> !txn_start);

  // R8
  drop_clear_chk: assert property (@(posedge clk) disable iff (rst)
    uframe_start |=> drop_count == '0);

  // R9
  ovf_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    overflow |=> overflow);

  // R7
  refuse_latch_chk: assert property (@(posedge clk) disable iff (rst)
    (refused_q && !uframe_start) |=> !txn_start);
endmodule

// File: tb/sim_periodic_uframe_sched.sv
module sim_periodic_uframe_sched;
  localparam int N  = 8;
  localparam int PW = 11;
  localparam int FW = 11;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic          rst, uframe_start, txn_done, cfg_we, cfg_en;
  logic [2:0]    cfg_idx, cfg_ivl, txn_idx;
  logic [7:0]    cfg_smask;
  logic [PW-1:0] cfg_pkt, txn_bytes;
  logic          txn_start, overflow;
  logic [FW+2:0] frindex;
  logic [3:0]    drop_count;

  periodic_uframe_sched #(.N_ENTRIES(N), .PKT_W(PW), .FRAME_W(FW), .UFRAME_BYTES(3000),
    .EOF1_GUARD(200), .TXN_OVERHEAD(40)) u0 (
    .clk(clk), .rst(rst), .uframe_start(uframe_start), .txn_done(txn_done),
    .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_en(cfg_en), .cfg_smask(cfg_smask),
    .cfg_ivl(cfg_ivl), .cfg_pkt(cfg_pkt), .txn_start(txn_start), .txn_idx(txn_idx),
    .txn_bytes(txn_bytes), .frindex(frindex), .drop_count(drop_count), .overflow(overflow));

  // {grant mask, drop count} for microframes 0..23
  localparam logic [11:0] VEC [24] = '{
    12'h032, 12'h000, 12'h000, 12'h000, 12'h000, 12'h300, 12'h000, 12'h000,
    12'h032, 12'h000, 12'h000, 12'h000, 12'h000, 12'h100, 12'h000, 12'h000,
    12'h032, 12'h000, 12'h000, 12'h000, 12'h000, 12'h300, 12'h000, 12'h000};

  int   checks = 0, fails = 0;
  int   exp_pkt [N];
  logic [7:0] got_mask;
  int   last_idx;
  bit   busy;
  int   dly;
  bit   done_flag = 0;

  task automatic chk(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic cfg(int idx, bit en, logic [7:0] sm, logic [2:0] ivl, int pkt);
    @(negedge clk);
    cfg_we = 1'b1; cfg_idx = 3'(idx); cfg_en = en; cfg_smask = sm; cfg_ivl = ivl;
    cfg_pkt = PW'(pkt);
    @(negedge clk);
    cfg_we = 1'b0;
    exp_pkt[idx] = pkt;
  endtask

  task automatic uframe();
    @(negedge clk);
    got_mask = '0; last_idx = -1;
    uframe_start = 1'b1;
    @(negedge clk);
    uframe_start = 1'b0;
    repeat (80) @(negedge clk);
  endtask

  // Transaction engine model: done three cycles after each start.
  initial begin
    txn_done = 1'b0; busy = 0; dly = 0;
    forever begin
      @(negedge clk);
      txn_done = 1'b0;
      if (busy) begin
        if (dly == 0) begin txn_done = 1'b1; busy = 0; end
        else dly--;
      end
      if (txn_start) begin
        chk("R4", "start while busy", int'(busy), 0);
        chk("R4", "ascending order", int'(int'(txn_idx) > last_idx), 1);
        chk("R5", "txn_bytes", int'(txn_bytes), exp_pkt[txn_idx]);
        got_mask[txn_idx] = 1'b1;
        last_idx = int'(txn_idx);
        busy = 1; dly = 2;
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done_flag) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; uframe_start = 1'b0; cfg_we = 1'b0; cfg_idx = '0; cfg_en = 1'b0;
    cfg_smask = '0; cfg_ivl = '0; cfg_pkt = '0;
    got_mask = '0; last_idx = -1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1", "reset frindex", int'(frindex), 16383);
    chk("R1", "reset txn_start", int'(txn_start), 0);
    chk("R1", "reset drop_count", int'(drop_count), 0);
    chk("R9", "reset overflow", int'(overflow), 0);

    // R10: load the table
    cfg(0, 1, 8'h01, 3'd0, 1024);
    cfg(1, 1, 8'h01, 3'd0, 1024);
    cfg(2, 1, 8'h01, 3'd0, 1024);
    cfg(3, 1, 8'h01, 3'd0, 64);
    cfg(4, 1, 8'h20, 3'd0, 512);
    cfg(5, 1, 8'h20, 3'd1, 512);
    cfg(6, 0, 8'hFF, 3'd0, 8);
    cfg(7, 1, 8'h00, 3'd0, 8);

    for (int m = 0; m < 24; m++) begin
      uframe();
      chk("R1", "frindex", int'(frindex), m);
      chk("R2 R3 R6", "grant mask", int'(got_mask), int'(VEC[m][11:4]));
      chk("R8", "drop_count", int'(drop_count), int'(VEC[m][3:0]));
      if (m == 0) begin
        chk("R7", "fitting entry 3 after refusal", int'(got_mask[3]), 0);
        chk("R9", "overflow set", int'(overflow), 1);
      end
      if (m == 1) chk("R9", "overflow held", int'(overflow), 1);
    end

    // R6 exact fit: 1064 + 1064 + 672 = 2800
    cfg(2, 1, 8'h01, 3'd0, 632);
    uframe();
    chk("R6", "exact fit mask", int'(got_mask), 8'h07);
    chk("R6", "exact fit drops", int'(drop_count), 1);
    for (int m = 25; m < 32; m++) uframe();

    // R6 one byte over
    cfg(2, 1, 8'h01, 3'd0, 633);
    uframe();
    chk("R6", "one over mask", int'(got_mask), 8'h03);
    chk("R6", "one over drops", int'(drop_count), 2);
    for (int m = 33; m < 40; m++) uframe();

    // R10 rewrite disables entry 0: everything else fits
    cfg(0, 0, 8'h01, 3'd0, 1024);
    uframe();
    chk("R10", "frindex", int'(frindex), 40);
    chk("R10", "mask after disable", int'(got_mask), 8'h0E);
    chk("R10", "drops after disable", int'(drop_count), 0);
    chk("R9", "overflow still held", int'(overflow), 1);

    done_flag = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule